// File: doc/BRIEF.md
# Shared-Exponent Complex Butterfly

This block is the arithmetic core of a memory-based radix-2 decimation-in-frequency FFT engine. Every complex value it handles is a 21-bit compact word: one 3-bit exponent that the real and imaginary parts share, and two 9-bit two's-complement fractions that carry no hidden leading one. Each clock it can take two such operands and a twiddle factor. It returns the sum of the operands and their difference rotated by the twiddle, both packed back into the same compact format.

Before the add and subtract, the operands are aligned to a common exponent. After the twiddle product, each result is normalized, rounded and saturated back to 9-bit fractions. A signed stage bias, loaded at the start of each FFT pass, moves the range that the 3-bit exponent covers. The block also keeps the largest output exponent produced since the bias was loaded, so an external controller can choose the bias for the next pass.

The pipeline has a fixed depth of five registers and accepts one butterfly per cycle. Address generation, storage, twiddle tables and the pass controller sit outside the block.

Top module: `hfp_butterfly`

## Requirements
- R1: A word packs the exponent in bits [20:18], the real fraction in bits [17:9] and the imaginary fraction in bits [8:0], both two's-complement. An input word is worth fraction·2^(exponent−8). An output word is worth fraction·2^(exponent+bias−8), where bias is the latched stage bias.
- R2: The operand with the smaller exponent has both fractions arithmetically shifted right (floor) by the exponent difference. The larger exponent becomes the shared working exponent. When the exponents are equal, neither operand is shifted.
- R3: The sum and the difference are formed at 10 bits per part without loss, at the working exponent.
- R4: The twiddle is {real[19:10], imag[9:0]}, signed, with 256 meaning 1.0. The rotated difference is (dr·wr − di·wi, dr·wi + di·wr), arithmetically shifted right by 8 (floor).
- R5: Each result is normalized so that the larger magnitude of its two parts lies in [128,255]. Right shifts by R round half up, meaning 2^(R−1) is added before the floor shift. Left shifts lower the exponent. Fractions are clamped to [−256,255].
- R6: The stored exponent is the normalized exponent minus the bias. If that value is below 0, the fractions are shifted right further by the shortfall, with the same rounding, and the exponent is stored as 0.
- R7: If the stored exponent would exceed 7, it becomes 7. Positive parts saturate to 255, negative parts to −256, and zero parts stay 0.
- R8: A result whose two parts are both zero is stored as the all-zero word.
- R9: out_valid follows in_valid exactly 5 cycles later, and one butterfly can be accepted every cycle.
- R10: stage_start loads bias_in into the bias register and clears max_exp. One cycle after each valid output, max_exp holds the largest stored exponent of all outputs since the last clear.
- R11: After reset, out_valid is 0, max_exp is 0 and the bias is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_start | input | 1 | Loads the bias and clears the exponent maximum |
| bias_in | input | 4 | Signed stage bias |
| in_valid | input | 1 | Operands and twiddle are valid |
| op_a | input | 21 | First complex operand |
| op_b | input | 21 | Second complex operand |
| twiddle | input | 20 | Twiddle factor, real in the upper half |
| out_valid | output | 1 | Results are valid |
| out_sum | output | 21 | Packed sum |
| out_dif | output | 21 | Packed rotated difference |
| max_exp | output | 3 | Largest stored output exponent in this stage |

## Verification
The bench builds the block with its default widths: 3-bit exponents, 9-bit fractions, 10-bit twiddles and a 4-bit bias. With a 4-bit bias, the range from −8 to +7 is enough to force both clamp regions of the 3-bit exponent. A bias of −8 with large operands drives results into saturation, and a bias of 7 with small operands drives them into denormal right shifts. Unbiased random bursts, run back to back, cover alignment, left normalization, rounding carries into the clamp and the −256 corner of the twiddle.

// File: rtl/bfy_pkg.sv
package bfy_pkg;
  // default geometry of the compact complex word
  localparam int HFP_EXP_W  = 3;
  localparam int HFP_FRAC_W = 9;
  localparam int HFP_TW_W   = 10;
  localparam int HFP_BIAS_W = 4;
endpackage

// File: rtl/bfy_align.sv
// Pipeline stage 1: bring both operands to the larger exponent.
module bfy_align #(
  parameter int EXP_W  = 3,
  parameter int FRAC_W = 9
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             v_i,
  input  logic [EXP_W+2*FRAC_W-1:0]        a_w,
  input  logic [EXP_W+2*FRAC_W-1:0]        b_w,
  output logic                             v_o,
  output logic signed [FRAC_W-1:0]         ar_o,
  output logic signed [FRAC_W-1:0]         ai_o,
  output logic signed [FRAC_W-1:0]         br_o,
  output logic signed [FRAC_W-1:0]         bi_o,
  output logic [EXP_W-1:0]                 e_o
);
  localparam int WW = EXP_W + 2*FRAC_W;

  logic [EXP_W-1:0]         ea, eb, ediff;
  logic signed [FRAC_W-1:0] ar, ai, br, bi;
  logic                     a_big;

  always_comb begin
    ea    = a_w[WW-1 -: EXP_W];
    eb    = b_w[WW-1 -: EXP_W];
    ar    = $signed(a_w[2*FRAC_W-1 -: FRAC_W]);
    ai    = $signed(a_w[FRAC_W-1:0]);
    br    = $signed(b_w[2*FRAC_W-1 -: FRAC_W]);
    bi    = $signed(b_w[FRAC_W-1:0]);
    a_big = (ea >= eb);
    ediff = a_big ? (ea - eb) : (eb - ea);
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    ar_o <= a_big ? ar : (ar >>> ediff);
    ai_o <= a_big ? ai : (ai >>> ediff);
    br_o <= a_big ? (br >>> ediff) : br;
    bi_o <= a_big ? (bi >>> ediff) : bi;
    e_o  <= a_big ? ea : eb;
  end
endmodule

// File: rtl/bfy_rotate.sv
// Pipeline stages 2 and 3: add/subtract, then twiddle rotation of the difference.
module bfy_rotate #(
  parameter int EXP_W  = 3,
  parameter int FRAC_W = 9,
  parameter int TW_W   = 10,
  parameter int MID_W  = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      v_i,
  input  logic signed [FRAC_W-1:0]  ar_i,
  input  logic signed [FRAC_W-1:0]  ai_i,
  input  logic signed [FRAC_W-1:0]  br_i,
  input  logic signed [FRAC_W-1:0]  bi_i,
  input  logic [EXP_W-1:0]          e_i,
  input  logic [2*TW_W-1:0]         tw_i,
  output logic                      v_o,
  output logic signed [MID_W-1:0]   sr_o,
  output logic signed [MID_W-1:0]   si_o,
  output logic signed [MID_W-1:0]   pr_o,
  output logic signed [MID_W-1:0]   pi_o,
  output logic [EXP_W-1:0]          e_o
);
  localparam int SW      = FRAC_W + 1;      // lossless add width
  localparam int PW      = SW + TW_W + 1;   // full complex product width
  localparam int TW_FRAC = TW_W - 2;        // twiddle fraction bits

  // stage 2 registers
  logic                   v2;
  logic [EXP_W-1:0]       e2;
  logic signed [SW-1:0]   sr2, si2, dr2, di2;
  logic signed [TW_W-1:0] wr2, wi2;

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v_i;
    e2  <= e_i;
    sr2 <= SW'(ar_i) + SW'(br_i);
    si2 <= SW'(ai_i) + SW'(bi_i);
    dr2 <= SW'(ar_i) - SW'(br_i);
    di2 <= SW'(ai_i) - SW'(bi_i);
    wr2 <= $signed(tw_i[2*TW_W-1 -: TW_W]);
    wi2 <= $signed(tw_i[TW_W-1:0]);
  end

  // stage 3: four real products, two adders, truncation to the trimmed width
  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir, pr_f, pi_f;

  always_comb begin
    m_rr = PW'(dr2) * PW'(wr2);
    m_ii = PW'(di2) * PW'(wi2);
    m_ri = PW'(dr2) * PW'(wi2);
    m_ir = PW'(di2) * PW'(wr2);
    pr_f = (m_rr - m_ii) >>> TW_FRAC;
    pi_f = (m_ri + m_ir) >>> TW_FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v2;
    e_o  <= e2;
    sr_o <= MID_W'(sr2);
    si_o <= MID_W'(si2);
    pr_o <= MID_W'(pr_f);
    pi_o <= MID_W'(pi_f);
  end
endmodule

// File: rtl/bfy_norm.sv
// Pipeline stages 4 and 5 for one result lane: shift planning, then shift/round/saturate.
module bfy_norm #(
  parameter int EXP_W  = 3,
  parameter int FRAC_W = 9,
  parameter int BIAS_W = 4,
  parameter int IN_W   = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      v_i,
  input  logic signed [IN_W-1:0]    re_i,
  input  logic signed [IN_W-1:0]    im_i,
  input  logic [EXP_W-1:0]          e_i,
  input  logic signed [BIAS_W-1:0]  bias,
  output logic                      v_o,
  output logic signed [FRAC_W-1:0]  re_o,
  output logic signed [FRAC_W-1:0]  im_o,
  output logic [EXP_W-1:0]          e_o
);
  localparam int MAG_W   = IN_W + 1;
  localparam int CW      = $clog2(MAG_W) + EXP_W + BIAS_W;
  localparam int XW      = IN_W + 2;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int TGT     = FRAC_W - 2;     // leading-one position after normalization
  localparam logic signed [XW-1:0] FMAX = XW'((1 << (FRAC_W-1)) - 1);
  localparam logic signed [XW-1:0] FMIN = XW'(-(1 << (FRAC_W-1)));

  // ---------------- stage A: plan the shift and the stored exponent
  logic signed [MAG_W-1:0] rx, ix;
  logic [MAG_W-1:0]        mr, mi, mm;
  logic [CW-1:0]           lead;
  logic signed [CW-1:0]    s_c, et_c, r_c;
  logic [EXP_W-1:0]        eo_c;
  logic                    sat_c, zero_c;

  always_comb begin
    rx   = MAG_W'(re_i);
    ix   = MAG_W'(im_i);
    mr   = rx[MAG_W-1] ? MAG_W'(-rx) : MAG_W'(rx);
    mi   = ix[MAG_W-1] ? MAG_W'(-ix) : MAG_W'(ix);
    mm   = (mr > mi) ? mr : mi;
    lead = '0;
    for (int k = 0; k < MAG_W; k++) begin
      if (mm[k]) lead = CW'(k);
    end
    zero_c = (mm == '0);
    s_c    = $signed(lead) - CW'(TGT);
    et_c   = $signed(CW'(e_i)) + s_c - CW'(bias);
    r_c    = s_c;
    eo_c   = et_c[EXP_W-1:0];
    sat_c  = 1'b0;
    if (zero_c) begin
      r_c  = '0;
      eo_c = '0;
    end else if (et_c > CW'(EXP_MAX)) begin
      sat_c = 1'b1;
      eo_c  = EXP_W'(EXP_MAX);
    end else if (et_c < 0) begin
      r_c  = s_c - et_c;   // extra right shift for the exponent shortfall
      eo_c = '0;
    end
  end

  logic                    va, sat_a, zero_a;
  logic signed [IN_W-1:0]  re_a, im_a;
  logic signed [CW-1:0]    r_a;
  logic [EXP_W-1:0]        e_a;

  always_ff @(posedge clk) begin
    if (rst) va <= 1'b0;
    else     va <= v_i;
    re_a   <= re_i;
    im_a   <= im_i;
    r_a    <= r_c;
    e_a    <= eo_c;
    sat_a  <= sat_c;
    zero_a <= zero_c;
  end

  // ---------------- stage B: apply shift with round-half-up and saturation
  function automatic logic signed [FRAC_W-1:0] f_shape(
    input logic signed [IN_W-1:0] v,
    input logic signed [CW-1:0]   r,
    input logic                   sat,
    input logic                   zero
  );
    logic signed [XW-1:0] vx, w;
    logic [CW-1:0]        sh;
    vx = XW'(v);
    sh = '0;
    if (zero) begin
      w = '0;
    end else if (sat) begin
      w = v[IN_W-1] ? FMIN : ((v == '0) ? '0 : FMAX);
    end else if (r > 0) begin
      sh = CW'(r);
      w  = (vx + (XW'(1) <<< (sh - CW'(1)))) >>> sh;
    end else begin
      sh = CW'(-r);
      w  = vx <<< sh;
    end
    if (w > FMAX)      w = FMAX;
    else if (w < FMIN) w = FMIN;
    return FRAC_W'(w);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= va;
    re_o <= f_shape(re_a, r_a, sat_a, zero_a);
    im_o <= f_shape(im_a, r_a, sat_a, zero_a);
    e_o  <= e_a;
  end

  // ---------------- checks on the packed lane output
  logic signed [FRAC_W:0] re_w, im_w;
  logic [FRAC_W:0]        mag_re, mag_im;
  always_comb begin
    re_w   = (FRAC_W+1)'(re_o);
    im_w   = (FRAC_W+1)'(im_o);
    mag_re = re_w[FRAC_W] ? (FRAC_W+1)'(-re_w) : (FRAC_W+1)'(re_w);
    mag_im = im_w[FRAC_W] ? (FRAC_W+1)'(-im_w) : (FRAC_W+1)'(im_w);
  end

  // R5: away from both exponent clamps a result is normalized
  p_norm_r5: assert property (@(posedge clk) disable iff (rst)
    (v_o && e_o != '0 && e_o != EXP_W'(EXP_MAX)) |->
      ((mag_re >= (FRAC_W+1)'(1 << TGT)) || (mag_im >= (FRAC_W+1)'(1 << TGT))));

  // R8: an all-zero fraction pair always carries exponent 0
  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (v_o && re_o == '0 && im_o == '0) |-> (e_o == '0));
endmodule

// File: rtl/hfp_butterfly.sv
module hfp_butterfly #(
  parameter int EXP_W  = bfy_pkg::HFP_EXP_W,
  parameter int FRAC_W = bfy_pkg::HFP_FRAC_W,
  parameter int TW_W   = bfy_pkg::HFP_TW_W,
  parameter int BIAS_W = bfy_pkg::HFP_BIAS_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          stage_start,
  input  logic signed [BIAS_W-1:0]      bias_in,
  input  logic                          in_valid,
  input  logic [EXP_W+2*FRAC_W-1:0]     op_a,
  input  logic [EXP_W+2*FRAC_W-1:0]     op_b,
  input  logic [2*TW_W-1:0]             twiddle,
  output logic                          out_valid,
  output logic [EXP_W+2*FRAC_W-1:0]     out_sum,
  output logic [EXP_W+2*FRAC_W-1:0]     out_dif,
  output logic [EXP_W-1:0]              max_exp
);
  localparam int WW    = EXP_W + 2*FRAC_W;
  localparam int MID_W = (FRAC_W + 1) + (TW_W - (TW_W - 2)) + 1;
  localparam int LANES = 2;   // lane 0: sum, lane 1: rotated difference

  // stage bias and twiddle timing
  logic signed [BIAS_W-1:0] bias_q;
  logic [2*TW_W-1:0]        tw_q;

  always_ff @(posedge clk) begin
    if (rst)              bias_q <= '0;
    else if (stage_start) bias_q <= bias_in;
    tw_q <= twiddle;
  end

  // stage 1
  logic                     v1;
  logic signed [FRAC_W-1:0] ar1, ai1, br1, bi1;
  logic [EXP_W-1:0]         e1;

  bfy_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk(clk), .rst(rst), .v_i(in_valid), .a_w(op_a), .b_w(op_b),
    .v_o(v1), .ar_o(ar1), .ai_o(ai1), .br_o(br1), .bi_o(bi1), .e_o(e1)
  );

  // stages 2 and 3
  logic                    v3;
  logic signed [MID_W-1:0] sr3, si3, pr3, pi3;
  logic [EXP_W-1:0]        e3;

  bfy_rotate #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .TW_W(TW_W), .MID_W(MID_W)) u_rot (
    .clk(clk), .rst(rst), .v_i(v1),
    .ar_i(ar1), .ai_i(ai1), .br_i(br1), .bi_i(bi1), .e_i(e1), .tw_i(tw_q),
    .v_o(v3), .sr_o(sr3), .si_o(si3), .pr_o(pr3), .pi_o(pi3), .e_o(e3)
  );

  // stages 4 and 5: one normalizer per result
  logic signed [MID_W-1:0]  ln_re [LANES];
  logic signed [MID_W-1:0]  ln_im [LANES];
  logic                     ln_v  [LANES];
  logic signed [FRAC_W-1:0] ln_fr [LANES];
  logic signed [FRAC_W-1:0] ln_fi [LANES];
  logic [EXP_W-1:0]         ln_e  [LANES];

  assign ln_re[0] = sr3;
  assign ln_im[0] = si3;
  assign ln_re[1] = pr3;
  assign ln_im[1] = pi3;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfy_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS_W(BIAS_W), .IN_W(MID_W)) u_norm (
      .clk(clk), .rst(rst), .v_i(v3),
      .re_i(ln_re[g]), .im_i(ln_im[g]), .e_i(e3), .bias(bias_q),
      .v_o(ln_v[g]), .re_o(ln_fr[g]), .im_o(ln_fi[g]), .e_o(ln_e[g])
    );
  end

  assign out_valid = ln_v[0] & ln_v[1];
  assign out_sum   = {ln_e[0], ln_fr[0], ln_fi[0]};
  assign out_dif   = {ln_e[1], ln_fr[1], ln_fi[1]};

  // stage exponent maximum
  logic [EXP_W-1:0] max_q, e_hi;
  always_comb e_hi = (ln_e[0] > ln_e[1]) ? ln_e[0] : ln_e[1];

  always_ff @(posedge clk) begin
    if (rst)                               max_q <= '0;
    else if (stage_start)                  max_q <= '0;
    else if (out_valid && (e_hi > max_q))  max_q <= e_hi;
  end
  assign max_exp = max_q;

  // R9: a result only appears five cycles after an accepted butterfly
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 5));

  // R10: within a stage the maximum never falls
  p_max_mono_r10: assert property (@(posedge clk) disable iff (rst)
    !stage_start |=> (max_exp >= $past(max_exp)));

  // R10: the maximum covers every exponent that was produced
  p_max_cover_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !stage_start) |=>
      ((max_exp >= $past(out_sum[WW-1 -: EXP_W])) && (max_exp >= $past(out_dif[WW-1 -: EXP_W]))));
endmodule

// File: tb/hfp_butterfly_test.sv
module hfp_butterfly_test;
  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              stage_start = 1'b0;
  logic signed [3:0] bias_in = '0;
  logic              in_valid = 1'b0;
  logic [20:0]       op_a = '0, op_b = '0;
  logic [19:0]       twiddle = '0;
  logic              out_valid;
  logic [20:0]       out_sum, out_dif;
  logic [2:0]        max_exp;

  hfp_butterfly uut (
    .clk(clk), .rst(rst), .stage_start(stage_start), .bias_in(bias_in),
    .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .twiddle(twiddle),
    .out_valid(out_valid), .out_sum(out_sum), .out_dif(out_dif), .max_exp(max_exp)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          checks = 0, errors = 0, mdl_max = 0, cur_bias = 0;
  bit          mon_on = 0, done = 0;
  int unsigned seed = 32'h1357_9bdf;
  logic [41:0] exp_q[$];
  string       tag_q[$];
  int          iss_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ---------------- reference model from the requirements
  function automatic int rsh(input int v, input int r);
    int w;
    if (r > 0) w = (v + (1 << (r-1))) >>> r;
    else       w = v * (1 << (-r));
    if (w > 255)  w = 255;
    if (w < -256) w = -256;
    return w;
  endfunction

  function automatic int satv(input int v);
    return (v > 0) ? 255 : ((v < 0) ? -256 : 0);
  endfunction

  function automatic logic [20:0] ref_norm(input int re, input int im, input int e, input int b);
    int m, p, s, et, r, eo;
    if (re == 0 && im == 0) return '0;
    m = (re < 0) ? -re : re;
    if (((im < 0) ? -im : im) > m) m = (im < 0) ? -im : im;
    p = 0;
    for (int k = 0; k < 16; k++) if (m >= (1 << k)) p = k;
    s  = p - 7;
    et = e + s - b;
    if (et > 7) return {3'd7, 9'(satv(re)), 9'(satv(im))};
    if (et < 0) begin r = s - et; eo = 0; end
    else        begin r = s;      eo = et; end
    return {3'(eo), 9'(rsh(re, r)), 9'(rsh(im, r))};
  endfunction

  function automatic logic [41:0] ref_bfy(input logic [20:0] a, input logic [20:0] b,
                                          input logic [19:0] w, input int bias);
    int ea, eb, e, ar, ai, br, bi, sr, si, dr, di, wr, wi, pr, pim;
    ea = int'(a[20:18]); eb = int'(b[20:18]);
    ar = int'($signed(a[17:9])); ai = int'($signed(a[8:0]));
    br = int'($signed(b[17:9])); bi = int'($signed(b[8:0]));
    if (ea >= eb) begin br = br >>> (ea - eb); bi = bi >>> (ea - eb); e = ea; end
    else          begin ar = ar >>> (eb - ea); ai = ai >>> (eb - ea); e = eb; end
    sr = ar + br; si = ai + bi; dr = ar - br; di = ai - bi;
    wr = int'($signed(w[19:10])); wi = int'($signed(w[9:0]));
    pr  = (dr*wr - di*wi) >>> 8;
    pim = (dr*wi + di*wr) >>> 8;
    return {ref_norm(sr, si, e, bias), ref_norm(pr, pim, e, bias)};
  endfunction

  function automatic logic [20:0] mk(input int e, input int re, input int im);
    return {3'(e), 9'(re), 9'(im)};
  endfunction

  function automatic logic [19:0] tw(input int wr, input int wi);
    return {10'(wr), 10'(wi)};
  endfunction

  function int unsigned nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 7;
  endfunction

  // ---------------- driver
  task automatic push(input logic [20:0] a, input logic [20:0] b,
                      input logic [19:0] w, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; twiddle = w;
    exp_q.push_back(ref_bfy(a, b, w, cur_bias));
    tag_q.push_back(tag);
    iss_q.push_back(cyc);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic burst(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int unsigned r1, r2, r3;
      r1 = nxt(); r2 = nxt(); r3 = nxt();
      push(mk(int'(r1 % 8), int'((r1 >> 3) % 512) - 256, int'((r1 >> 12) % 512) - 256),
           mk(int'(r2 % 8), int'((r2 >> 3) % 512) - 256, int'((r2 >> 12) % 512) - 256),
           tw(int'(r3 % 513) - 256, int'((r3 >> 10) % 513) - 256), tag);
    end
    idle();
  endtask

  task automatic do_stage(input int b);
    idle();
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    chk(max_exp == 3'(mdl_max), "R10", "stage maximum", 64'(max_exp), 64'(mdl_max));
    stage_start = 1'b1; bias_in = 4'(b); cur_bias = b;
    @(negedge clk);
    stage_start = 1'b0; mdl_max = 0;
    chk(max_exp == 3'd0, "R10", "cleared maximum", 64'(max_exp), 64'd0);
  endtask

  // ---------------- monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (mon_on && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected output", 64'(out_sum), 64'd0);
      end else begin
        logic [41:0] ev;
        string tg;
        int iss;
        ev = exp_q.pop_front(); tg = tag_q.pop_front(); iss = iss_q.pop_front();
        chk({out_sum, out_dif} == ev, tg, "sum/difference words", 64'({out_sum, out_dif}), 64'(ev));
        chk(cyc - iss == 5, "R9", "latency", 64'(cyc - iss), 64'd5);
        chk(max_exp == 3'(mdl_max), "R10", "running maximum", 64'(max_exp), 64'(mdl_max));
        if (int'(out_sum[20:18]) > mdl_max) mdl_max = int'(out_sum[20:18]);
        if (int'(out_dif[20:18]) > mdl_max) mdl_max = int'(out_dif[20:18]);
      end
    end
  end

  // ---------------- watchdog
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      report();
    end
  end

  // ---------------- stimulus
  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid in reset", 64'(out_valid), 64'd0);
    chk(max_exp == 3'd0, "R11", "maximum in reset", 64'(max_exp), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid after reset", 64'(out_valid), 64'd0);
    mon_on = 1;

    // bias 0: directed arithmetic
    do_stage(0);
    push(mk(3, 100, -50), mk(3, 20, 30), tw(256, 0), "R3");
    push(mk(5, -200, 17), mk(2, 90, -91), tw(256, 0), "R2");
    push(mk(1, 7, -9), mk(6, 64, 3), tw(181, -181), "R2");
    push(mk(4, 120, 60), mk(4, -40, 80), tw(0, -256), "R4");
    push(mk(2, -256, 255), mk(2, 255, -256), tw(-512, -512), "R4");
    push(mk(6, 33, -77), mk(6, 33, -77), tw(181, -181), "R8");
    push(mk(0, 0, 0), mk(1, 0, 0), tw(200, 100), "R8");
    push(mk(2, 1, -1), mk(0, 0, 0), tw(256, 0), "R5");
    push(mk(7, 255, 127), mk(7, 1, 128), tw(256, 0), "R5");
    push(mk(5, -128, 0), mk(5, -128, 0), tw(256, 0), "R1");
    idle();

    // bias -8: results pushed above the exponent range
    do_stage(-8);
    push(mk(7, 255, 200), mk(7, 200, -256), tw(256, 0), "R7");
    push(mk(6, -256, 0), mk(6, -256, 0), tw(256, 256), "R7");
    push(mk(5, 0, 130), mk(4, 0, 90), tw(-256, 0), "R7");
    idle();

    // bias 7: results pushed below the exponent range
    do_stage(7);
    push(mk(0, 5, -3), mk(0, 2, 1), tw(256, 0), "R6");
    push(mk(3, 100, 50), mk(1, -60, 20), tw(0, 256), "R6");
    push(mk(7, 255, -255), mk(0, 1, 1), tw(181, 181), "R6");
    idle();

    // random back-to-back bursts under several biases
    do_stage(0);
    burst(150, "R5");
    do_stage(-3);
    burst(100, "R1");
    do_stage(2);
    burst(60, "R6");
    do_stage(-8);
    burst(40, "R7");
    do_stage(0);

    report();
  end
endmodule